// File: doc/BRIEF.md
# Configuration Unlock Key Detector

This block watches host I/O write cycles for an initiation key: a run of bytes that must equal, one after another, the states of an 8-bit linear feedback shift register started from 6Ah. The block produces each expected byte on the fly rather than reading it from a stored table. When the whole key has arrived in order, the block raises a flag that opens the configuration registers to the host. That flag stays set until reset.

Three fixed port addresses can carry the key. A fourth port is programmable and is used only while its enable is high. The first key write to any of these ports locks that address, and the rest of the sequence must use the same port. The block also outputs the current register value, so firmware or a debug path can see the next expected byte.

Top module: `cfg_key_detector`

## Requirements
- R1: While reset is asserted and right after it, `lfsr_q` is 8'h6A, `cfg_unlock` is 0 and no port is locked.
- R2: A write to the locked port whose data equals `lfsr_q` sets `lfsr_q` to `{lfsr_q[1]^lfsr_q[0], lfsr_q[7:1]}` on the next clock edge. From 6Ah the sequence runs B5h, DAh, EDh, F6h.
- R3: The candidate key ports are the addresses 16'h0279, 16'h03BD and 16'h03F0, plus `prog_addr` while `prog_en` is 1.
- R4: The first write to a candidate port locks that address until reset. A write to any other address, including another candidate port, leaves `lfsr_q` and `cfg_unlock` unchanged.
- R5: A write to the locked port whose data differs from `lfsr_q` reloads `lfsr_q` with 8'h6A and clears the match count. The port stays locked.
- R6: `cfg_unlock` goes to 1 on the edge that accepts the 32nd matching key byte in a row, and not before. It then stays 1 until reset.
- R7: While `prog_en` is 0, a write to `prog_addr` neither locks a port nor changes `lfsr_q`.
- R8: Once `cfg_unlock` is 1, later writes leave `lfsr_q` unchanged.
- R9: In a cycle where `wr_en` is 0, `lfsr_q` and `cfg_unlock` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host I/O write strobe, one cycle per write |
| wr_addr | input | 16 | Host I/O write address |
| wr_data | input | 8 | Host I/O write data byte |
| prog_addr | input | 16 | Programmable key port address |
| prog_en | input | 1 | Enables the programmable key port |
| cfg_unlock | output | 1 | Configuration access enabled (sticky) |
| lfsr_q | output | 8 | Current shift register value, which is the next expected key byte |

## Verification
The bench goes after port locking. It writes a correct byte to a second candidate port after the lock; a design that did not lock would advance the register there. It sends a wrong byte in the middle of the key, and a design that kept its count would unlock early or keep the wrong expected byte. It checks the boundary at 31 and 32 matching bytes, where an off-by-one count would raise the flag one byte early or late. It also writes to the programmable port while that port is disabled; a design that skipped the enable would lock that port and reject the later key on a fixed port.

// File: rtl/cfg_key_detector.sv
module cfg_key_detector #(
  parameter int          KEY_LEN = 32,
  parameter logic [7:0]  SEED    = 8'h6A,
  parameter logic [15:0] PORT_A  = 16'h0279,
  parameter logic [15:0] PORT_B  = 16'h03BD,
  parameter logic [15:0] PORT_C  = 16'h03F0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [15:0] prog_addr,
  input  logic        prog_en,
  output logic        cfg_unlock,
  output logic [7:0]  lfsr_q
);

  localparam int CW = $clog2(KEY_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(KEY_LEN - 1);

  logic          locked;
  logic [15:0]   lock_addr;
  logic [CW-1:0] match_cnt;

  logic cand_hit, port_ok, take, byte_ok;
  logic [7:0] lfsr_next;

  assign cand_hit  = (wr_addr == PORT_A) || (wr_addr == PORT_B) || (wr_addr == PORT_C) ||
                     (prog_en && (wr_addr == prog_addr));
  assign port_ok   = cand_hit && (!locked || (wr_addr == lock_addr));
  assign take      = wr_en && port_ok && !cfg_unlock;
  assign byte_ok   = (wr_data == lfsr_q);
  assign lfsr_next = {lfsr_q[1] ^ lfsr_q[0], lfsr_q[7:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q     <= SEED;
      match_cnt  <= '0;
      locked     <= 1'b0;
      lock_addr  <= '0;
      cfg_unlock <= 1'b0;
    end else if (take) begin
      if (!locked) begin
        locked    <= 1'b1;
        lock_addr <= wr_addr;
      end
      if (byte_ok) begin
        lfsr_q <= lfsr_next;
        if (match_cnt == LAST) begin
          cfg_unlock <= 1'b1;
          match_cnt  <= '0;
        end else begin
          match_cnt <= match_cnt + 1'b1;
        end
      end else begin
        lfsr_q    <= SEED;
        match_cnt <= '0;
      end
    end
  end

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(lfsr_q) && $stable(cfg_unlock));

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_unlock |=> cfg_unlock);

  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_unlock |=> $stable(lfsr_q));

  p_mismatch_seed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !byte_ok) |=> (lfsr_q == SEED) && !cfg_unlock);

  p_unlock_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_unlock) |-> $past(wr_en) && $past(wr_data) == $past(lfsr_q));

  p_locked_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked && $stable(lock_addr));

  p_off_port_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && locked && wr_addr != lock_addr) |=> $stable(lfsr_q));

endmodule

// File: tb/cfg_key_detector_bench.sv
module cfg_key_detector_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [15:0] prog_addr = 16'h0300;
  logic prog_en = 1'b0;
  logic cfg_unlock;
  logic [7:0] lfsr_q;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  cfg_key_detector u_cfg_key_detector (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .prog_addr(prog_addr), .prog_en(prog_en), .cfg_unlock(cfg_unlock), .lfsr_q(lfsr_q)
  );

  // {addr, data, expected lfsr after, expected unlock}
  localparam int NV = 8;
  localparam logic [32:0] VEC [NV] = '{
    {16'h0279, 8'h6A, 8'hB5, 1'b0},  // R2 R3 lock 0279
    {16'h03F0, 8'hB5, 8'hB5, 1'b0},  // R4 other candidate ignored
    {16'h0279, 8'hB5, 8'hDA, 1'b0},  // R2
    {16'h0100, 8'hDA, 8'hDA, 1'b0},  // R4 non-port ignored
    {16'h0279, 8'h00, 8'h6A, 1'b0},  // R5 mismatch reloads
    {16'h0279, 8'h6A, 8'hB5, 1'b0},  // R5 restart on same port
    {16'h0279, 8'hB5, 8'hDA, 1'b0},  // R2
    {16'h0279, 8'hDA, 8'hED, 1'b0}   // R2
  };

  function automatic logic [7:0] step(input logic [7:0] v);
    return {v[1] ^ v[0], v[7:1]};
  endfunction

  task automatic check(input string req, input logic [7:0] exp_l, input logic exp_u);
    n_vec++;
    if (lfsr_q !== exp_l || cfg_unlock !== exp_u) begin
      n_bad++;
      $display("FAIL %s: lfsr=%h unlock=%b expected lfsr=%h unlock=%b", req, lfsr_q, cfg_unlock, exp_l, exp_u);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] m;
    repeat (3) @(negedge clk);
    check("R1", 8'h6A, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 8'h6A, 1'b0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][32:17], VEC[i][16:9]);
      check("R2/R4/R5 vector", VEC[i][8:1], VEC[i][0]);
    end

    repeat (3) @(negedge clk);
    check("R9", 8'hED, 1'b0);

    // R6: full key on 03BD
    do_reset();
    check("R1", 8'h6A, 1'b0);
    m = 8'h6A;
    for (int i = 0; i < 31; i++) begin
      wr(16'h03BD, m);
      m = step(m);
    end
    check("R6 after 31", m, 1'b0);
    wr(16'h03BD, m);
    m = step(m);
    check("R6 after 32", m, 1'b1);
    wr(16'h03BD, 8'h00);
    check("R8 mismatch after unlock", m, 1'b1);
    wr(16'h03BD, m);
    check("R8 match after unlock", m, 1'b1);
    repeat (4) @(negedge clk);
    check("R6 sticky", m, 1'b1);

    // R7: disabled programmable port
    do_reset();
    prog_en = 1'b0;
    wr(16'h0300, 8'h6A);
    check("R7 disabled prog", 8'h6A, 1'b0);
    wr(16'h03F0, 8'h6A);
    check("R7 fixed port not blocked", 8'hB5, 1'b0);

    // R3: enabled programmable port
    do_reset();
    prog_en = 1'b1;
    wr(16'h0300, 8'h6A);
    check("R3 prog port", 8'hB5, 1'b0);
    wr(16'h0279, 8'hB5);
    check("R4 locked to prog", 8'hB5, 1'b0);
    wr(16'h0300, 8'hB5);
    check("R3 prog continue", 8'hDA, 1'b0);

    // R1: reset mid-sequence clears lock
    do_reset();
    prog_en = 1'b0;
    check("R1 mid reset", 8'h6A, 1'b0);
    wr(16'h0279, 8'h6A);
    check("R1 lock cleared", 8'hB5, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule